// File: doc/BRIEF.md
# Serial Audio Slave Transmitter

This block drives the data line of a three-wire stereo serial audio link: a bit clock, a word select and serial data. The bit clock and word select come from an external timing master. The block samples both of them in its own faster system clock domain and detects the bit-clock edges there. It then places two's-complement samples on the data line, most significant bit first. The left and right channels share the line, and the word-select level decides which channel is being sent.

A host supplies samples through a valid/ready handshake, one holding register per channel. Each change of the captured word select marks the start of a new channel slot. On the next falling bit-clock edge the holding word for the new channel is loaded into an output shift register. Every later falling edge shifts the register left and fills the bottom with a zero. The receiver can therefore take any slot length. A slot longer than the sample is padded with zeros, and a shorter slot simply cuts the sample off. If the host has not refreshed a channel by the time that channel is loaded, the old sample goes out again and an underrun pulse is raised.

Top module: `stereo_slave_tx`

## Requirements
- R1: While reset is held and afterwards until the first word-select change, `sdata_out` is 0, `underrun` is 0 and both ready outputs are 1. A new reset discards any pending sample and returns both ready outputs to 1.
- R2: A word-select change to 1 loads the right holding word, and a change to 0 loads the left holding word (low = left, high = right).
- R3: The loaded word is sent MSB first. Its MSB is on `sdata_out` during the whole bit period that starts at the first falling bit-clock edge after the one at which word select changed. The final bit of a slot is sent during the bit period in which the next word-select change happens.
- R4: After the transmitter's LSB, every further bit in the same slot is 0.
- R5: When a slot is shorter than SAMPLE_W bit periods, only the leading bits are sent. The next word's MSB still appears one bit period after the following word-select change.
- R6: `sdata_out` changes only in response to a falling bit-clock edge. It holds its value through the high phase of the bit clock.
- R7: With word select held steady, no word is loaded. A sample written in the middle of a slot stays pending: the ready output stays 0, no underrun is reported and the data line keeps shifting the current word.
- R8: Each channel's ready output is 1 exactly when its holding register has no unsent sample. A transfer takes place on a clock where valid and ready are both 1, and ready is 0 on the following clock. Ready returns to 1 only when that channel is loaded.
- R9: When a channel is loaded without a fresh sample, its previous sample is sent again and `underrun` is 1 for exactly one system clock. It is never 1 while the host keeps both channels supplied.
- R10: The bit clock and word select each pass through SYNC_STAGES flops. A bit-clock edge gives a single-cycle strobe. With the default of 2 stages, `sdata_out` takes its new value on the third system clock edge after the bit clock falls at the pin, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | External bit clock |
| ws_in | input | 1 | External word select, 0 = left, 1 = right |
| sdata_out | output | 1 | Serial data, changes after falling bit-clock edges |
| left_data | input | SAMPLE_W | Left sample from host |
| left_valid | input | 1 | Left sample valid |
| left_ready | output | 1 | Left holding register can accept |
| right_data | input | SAMPLE_W | Right sample from host |
| right_valid | input | 1 | Right sample valid |
| right_ready | output | 1 | Right holding register can accept |
| underrun | output | 1 | One-cycle pulse when a stale sample is sent |

## Verification
Slot lengths of 12, 16, 17, 20 and 24 bit periods are run against samples with an edge bit set at either end. A design with an off-by-one load would shift every word by one position, and one without zero fill would repeat bits or send stale ones after the LSB. A sample written in the middle of a slot catches a design that reloads without a word-select change: it would send that sample early and raise ready. A frame without any writes checks that both old samples are sent again with exactly two underrun pulses. Every bit period is sampled two and three system clocks after the bit clock falls. This catches a synchronizer that is one stage short or one stage too long.

// File: rtl/stx_pkg.sv
package stx_pkg;
  // Channel index carried by the word-select level
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/stx_edge_sync.sv
module stx_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic ws_in,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic ws_sync
);
  localparam int unsigned LAST = STAGES - 1;

  // bit 0 = bit clock, bit 1 = word select
  logic [1:0] chain [STAGES];
  logic       bclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      bclk_prev <= 1'b0;
    end else begin
      chain[0] <= {ws_in, bclk_in};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      bclk_prev <= chain[LAST][0];
    end
  end

  assign bclk_rise = chain[LAST][0] & ~bclk_prev;
  assign bclk_fall = ~chain[LAST][0] & bclk_prev;
  assign ws_sync   = chain[LAST][1];
endmodule

// File: rtl/stx_frame.sv
module stx_frame
  import stx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bclk_rise,
  input  logic  bclk_fall,
  input  logic  ws_sync,
  output logic  load_stb,
  output chan_e load_chan
);
  logic ws_cap;
  logic ws_dly;

  function automatic logic level_changed(input logic now_v, input logic old_v);
    return now_v ^ old_v;
  endfunction

  // Word select is captured on rising bit-clock edges; the delayed copy
  // lags it by one bit period, so they differ for one bit period per change.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_cap <= 1'b0;
      ws_dly <= 1'b0;
    end else if (bclk_rise) begin
      ws_cap <= ws_sync;
      ws_dly <= ws_cap;
    end
  end

  assign load_stb  = bclk_fall & level_changed(ws_cap, ws_dly);
  assign load_chan = chan_e'(ws_cap);
endmodule

// File: rtl/stx_hold_reg.sv
module stx_hold_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         consume,
  output logic [W-1:0] word,
  output logic         underrun
);
  logic fresh;
  logic accept;

  function automatic logic next_fresh(input logic cur, input logic acc, input logic con);
    if (acc) return 1'b1;
    if (con) return 1'b0;
    return cur;
  endfunction

  assign in_ready = ~fresh;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word     <= '0;
      fresh    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (accept) word <= in_data;
      fresh    <= next_fresh(fresh, accept, consume);
      underrun <= consume & ~fresh;
    end
  end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_stb,
  input  logic         load_stb,
  input  logic [W-1:0] load_word,
  output logic         sdata
);
  logic [W-1:0] sreg;

  // Serial fill is tied low: bits past the LSB are zero
  function automatic logic [W-1:0] shift_zero_fill(input logic [W-1:0] v);
    return {v[W-2:0], 1'b0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sreg <= '0;
    else if (load_stb)  sreg <= load_word;
    else if (shift_stb) sreg <= shift_zero_fill(sreg);
  end

  assign sdata = sreg[W-1];
endmodule

// File: rtl/stereo_slave_tx.sv
module stereo_slave_tx
  import stx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_in,
  input  logic                ws_in,
  output logic                sdata_out,
  input  logic [SAMPLE_W-1:0] left_data,
  input  logic                left_valid,
  output logic                left_ready,
  input  logic [SAMPLE_W-1:0] right_data,
  input  logic                right_valid,
  output logic                right_ready,
  output logic                underrun
);
  // Named internal events, also observed by the bound checker
  logic              rise_stb;
  logic              fall_stb;
  logic              ws_sync;
  logic              load_stb;
  chan_e             load_chan;
  logic [SAMPLE_W-1:0] load_word;

  logic [SAMPLE_W-1:0] ch_data [NUM_CH];
  logic [SAMPLE_W-1:0] ch_word [NUM_CH];
  logic [NUM_CH-1:0]   ch_valid;
  logic [NUM_CH-1:0]   ch_ready;
  logic [NUM_CH-1:0]   ch_sel;
  logic [NUM_CH-1:0]   ch_underrun;

  function automatic logic [NUM_CH-1:0] chan_onehot(input chan_e ch);
    logic [NUM_CH-1:0] v;
    v = '0;
    v[ch] = 1'b1;
    return v;
  endfunction

  stx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_in   (bclk_in),
    .ws_in     (ws_in),
    .bclk_rise (rise_stb),
    .bclk_fall (fall_stb),
    .ws_sync   (ws_sync)
  );

  stx_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_rise (rise_stb),
    .bclk_fall (fall_stb),
    .ws_sync   (ws_sync),
    .load_stb  (load_stb),
    .load_chan (load_chan)
  );

  assign ch_data[CH_LEFT]  = left_data;
  assign ch_data[CH_RIGHT] = right_data;
  assign ch_valid = {right_valid, left_valid};
  assign ch_sel   = chan_onehot(load_chan);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hold
    stx_hold_reg #(.W(SAMPLE_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_data  (ch_data[c]),
      .in_valid (ch_valid[c]),
      .in_ready (ch_ready[c]),
      .consume  (load_stb & ch_sel[c]),
      .word     (ch_word[c]),
      .underrun (ch_underrun[c])
    );
  end

  assign load_word = ch_word[load_chan];

  stx_shifter #(.W(SAMPLE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_stb (fall_stb),
    .load_stb  (load_stb),
    .load_word (load_word),
    .sdata     (sdata_out)
  );

  assign left_ready  = ch_ready[CH_LEFT];
  assign right_ready = ch_ready[CH_RIGHT];
  assign underrun    = |ch_underrun;
endmodule

// File: rtl/stereo_slave_tx_chk.sv
module stereo_slave_tx_chk
  import stx_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rise_stb,
  input logic              fall_stb,
  input logic              load_stb,
  input logic              sdata_out,
  input logic              underrun,
  input logic [W-1:0]      load_word,
  input logic [NUM_CH-1:0] ch_valid,
  input logic [NUM_CH-1:0] ch_ready
);
  AST_DATA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_out) |-> $past(fall_stb)); // R6
  AST_EDGE_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb})); // R10
  AST_FALL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb); // R10
  AST_MSB_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (sdata_out == $past(load_word[W-1]))); // R3
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb); // R7
  AST_UNDERRUN_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(load_stb)); // R9
  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun); // R9

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_valid[c] && ch_ready[c]) |=> !ch_ready[c]); // R8
    AST_READY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_ready[c]) |-> $past(load_stb)); // R8
  end
endmodule

bind stereo_slave_tx stereo_slave_tx_chk #(.W(SAMPLE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rise_stb  (rise_stb),
  .fall_stb  (fall_stb),
  .load_stb  (load_stb),
  .sdata_out (sdata_out),
  .underrun  (underrun),
  .load_word (load_word),
  .ch_valid  (ch_valid),
  .ch_ready  (ch_ready)
);

// File: tb/stereo_slave_tx_test.sv
module stereo_slave_tx_test;
  localparam int W  = 16;
  localparam int NV = 6;
  // {left, right, slot length in bit periods}
  localparam logic [39:0] VECS [NV] = '{
    {16'hA5C3, 16'h3C5A, 8'd16},
    {16'h8001, 16'h7FFE, 8'd20},
    {16'hFFFF, 16'h0000, 8'd12},
    {16'h1234, 16'hFEDC, 8'd24},
    {16'h4000, 16'h0002, 8'd17},
    {16'hC0DE, 16'h5EED, 8'd16}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         bclk  = 1'b1;
  logic         ws    = 1'b0;
  logic         sdata;
  logic [W-1:0] ldat = '0;
  logic [W-1:0] rdat = '0;
  logic         lval = 1'b0;
  logic         rval = 1'b0;
  logic         lrdy;
  logic         rrdy;
  logic         und;

  int n_chk = 0;
  int n_bad = 0;
  int und_cnt = 0;
  logic         exp_last = 1'b0;
  logic [W-1:0] prev_word = '0;
  int           prev_len = 1000;

  stereo_slave_tx #(.SAMPLE_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .ws_in(ws), .sdata_out(sdata),
    .left_data(ldat), .left_valid(lval), .left_ready(lrdy),
    .right_data(rdat), .right_valid(rval), .right_ready(rrdy),
    .underrun(und)
  );

  always @(negedge clk) if (rst_n && und === 1'b1) und_cnt++;

  function automatic logic wbit(input logic [W-1:0] w, input int idx);
    if (idx < W) return w[W-1-idx];
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bit period: fall (ws may change), low phase, rise, high phase
  task automatic bit_period(input logic wsv, input logic expb, input string tag);
    @(negedge clk);
    bclk = 1'b0;
    ws   = wsv;
    repeat (2) @(negedge clk);
    check("R10 not yet updated two clocks after fall", sdata, exp_last);
    @(negedge clk);
    check("R10 updated three clocks after fall", sdata, expb);
    repeat (5) @(negedge clk);
    check(tag, sdata, expb);
    bclk = 1'b1;
    repeat (8) @(negedge clk);
    check("R6 held through high phase", sdata, expb);
    exp_last = expb;
  endtask

  task automatic run_slot(input logic wsv, input logic [W-1:0] word, input int len);
    for (int p = 0; p < len; p++) begin
      logic  expb;
      string tag;
      if (p == 0) begin
        expb = wbit(prev_word, prev_len - 1);
        tag  = (prev_len < W) ? "R5 truncated word ends at slot edge"
                              : "R3 final bit of previous slot";
      end else begin
        expb = wbit(word, p - 1);
        if (p == 1)          tag = "R3 MSB one period after change";
        else if (p - 1 < W)  tag = wsv ? "R2 right word bit" : "R2 left word bit";
        else                 tag = "R4 zero fill after LSB";
      end
      bit_period(wsv, expb, tag);
    end
    prev_word = word;
    prev_len  = len;
  endtask

  task automatic push(input logic ch, input logic [W-1:0] d);
    @(negedge clk);
    check(ch ? "R8 right ready before write" : "R8 left ready before write",
          ch ? rrdy : lrdy, 1);
    if (ch) begin rdat = d; rval = 1'b1; end
    else    begin ldat = d; lval = 1'b1; end
    @(negedge clk);
    rval = 1'b0;
    lval = 1'b0;
    check("R8 ready low after transfer", ch ? rrdy : lrdy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 data low in reset", sdata, 0);
    check("R1 left ready in reset", lrdy, 1);
    check("R1 right ready in reset", rrdy, 1);
    check("R1 no underrun in reset", und, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 3; k++) bit_period(1'b0, 1'b0, "R1 idle data low");

    // Vector table: both channels supplied before every frame
    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] lw;
      logic [W-1:0] rw;
      int           len;
      lw  = VECS[i][39:24];
      rw  = VECS[i][23:8];
      len = int'(VECS[i][7:0]);
      push(1'b1, rw);
      push(1'b0, lw);
      run_slot(1'b1, rw, len);
      run_slot(1'b0, lw, len);
    end
    check("R9 no underrun while supplied", und_cnt, 0);

    // No writes: both previous samples resent, two underrun pulses
    run_slot(1'b1, 16'h5EED, 16);
    run_slot(1'b0, 16'hC0DE, 16);
    check("R9 two underrun pulses for stale frame", und_cnt, 2);

    // Word select held: a mid-slot write must stay pending
    push(1'b0, 16'h9999);
    for (int k = 0; k < 20; k++)
      bit_period(1'b0, wbit(16'hC0DE, 15 + k), "R7 no reload without ws change");
    check("R7 pending sample not consumed", lrdy, 0);
    check("R7 no underrun without load", und_cnt, 2);

    // Reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset clears pending sample", lrdy, 1);
    check("R1 reset clears data", sdata, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule